// File: doc/BRIEF.md
# LPC Host Interrupt Status Unit

This block gathers every interrupt and error source of a low-pin-count bus host controller into one 32-bit latched status word. Seventeen serial-interrupt level lines occupy the upper bits. A bus-reset event, six classes of bus error and two bus-master request strobes occupy the lower bits. Software reads the status, acknowledges bits by writing ones, and selects with an enable mask which latched bits raise the host interrupt. The address that goes with the first bus error is held in a capture register, so software can report where the fault happened.

The host interrupt feeds a second, upstream level that has its own sticky status bit, mask bit and polarity bit. That level drives the single interrupt line that leaves the block. A control register gates the serial-interrupt inputs and selects an auto-clear mode, in which each serial latch tracks its line and needs no acknowledge. It also holds the quiet-mode and start-frame-width settings for the serial engine, which lies outside this block. All registers sit behind a simple 32-bit register port with combinational read data.

Top module: `lpc_irq_hub`

## Requirements
- R1: After reset, every readable register returns 0 and both `host_irq` and `master_irq` are low.
- R2: With serial enable (control bit 31) set, a high on `sirq_lvl[n]` sets status bit 31−n one cycle later. With serial enable clear, the serial inputs set no status bit.
- R3: A pulse on `bus_rst_evt` sets status bit 10 and a pulse on `err_evt[i]` sets status bit 2+i. A pulse on `bm_req[0]` sets bit 1 and a pulse on `bm_req[1]` sets bit 0. Each of these bits stays set until it is acknowledged.
- R4: Writing status (offset 0x38) clears each bit written as 1 and leaves each bit written as 0 unchanged. An event bit whose source pulses in the same cycle as its clear ends up set.
- R5: Outside auto-clear mode, a serial latch that is cleared while its line is still high reads 0 right after the clear and reads 1 again one cycle later.
- R6: With auto-clear (control bit 23) set, each serial latch equals its gated input from the previous cycle and falls without any write.
- R7: `host_irq` is high exactly when a status bit and the same mask bit (offset 0x34) are both 1. The mask reads back only the implemented bits, 0xFFFF84FF.
- R8: The control register (offset 0x30) keeps bits 31, 30, 25:24 and 23 and reads 0 in every other bit.
- R9: The error address register (offset 0x40) captures `err_addr` on an `err_evt` pulse only while status bits 10 and 7:2 are all clear. The request bits 1:0 do not block capture.
- R10: Upstream status bit 11 (offset 0x50) is set in every cycle after one with `host_irq` high. Writing 1 to it clears it only when `host_irq` is low.
- R11: `master_irq` equals (upstream status AND upstream mask bit 11, offset 0x54) XOR polarity bit 11 (offset 0x58). Upstream mask and polarity read back only bit 11.
- R12: Reads of unmapped offsets return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | Write when high, read when low |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| sirq_lvl | input | 17 | Serial interrupt levels; index n maps to status bit 31−n |
| bus_rst_evt | input | 1 | Bus reset event pulse |
| err_evt | input | 6 | Bus error class pulses; index i maps to status bit 2+i |
| err_addr | input | 32 | Faulting address that goes with `err_evt` |
| bm_req | input | 2 | Bus-master request pulses (index 0 to bit 1, index 1 to bit 0) |
| host_irq | output | 1 | OR of masked host status |
| master_irq | output | 1 | Upstream interrupt after mask and polarity |

## Verification
The embedded properties check on every cycle that event pulses always land in the status word and that disabled serial lines never raise a latch. In auto-clear mode they check that each serial latch follows its line, and outside it that a serial clear takes effect. They also check that the captured error address stays frozen while an error-class bit is set, and that the upstream status bit follows the host interrupt. Some behaviour only the directed scenarios can show: the exact bit positions seen through the register port, the one-cycle gap before a level-held serial latch re-arms, and the rule that an event arriving with its own clear survives. The same holds for readback of reserved fields, the polarity inversion of `master_irq`, and the order in which first and later faulting addresses are captured.

// File: rtl/lpc_irq_pkg.sv
package lpc_irq_pkg;
  localparam int REG_W  = 32;
  localparam int SIRQ_N = 17;
  localparam int ERR_N  = 6;
  localparam int BM_N   = 2;

  localparam logic [7:0] OFS_SCTL  = 8'h30;
  localparam logic [7:0] OFS_MASK  = 8'h34;
  localparam logic [7:0] OFS_STAT  = 8'h38;
  localparam logic [7:0] OFS_EADR  = 8'h40;
  localparam logic [7:0] OFS_MSTAT = 8'h50;
  localparam logic [7:0] OFS_MMASK = 8'h54;
  localparam logic [7:0] OFS_MPOL  = 8'h58;

  localparam int BIT_BUSRST = 10;
  localparam int BIT_ERR_LO = 2;
  localparam int BIT_BM0    = 1;
  localparam int BIT_BM1    = 0;
  localparam int BIT_CASC   = 11;

  localparam int SCTL_EN    = 31;
  localparam int SCTL_QUIET = 30;
  localparam int SCTL_WHI   = 25;
  localparam int SCTL_WLO   = 24;
  localparam int SCTL_AUTO  = 23;

  localparam logic [REG_W-1:0] ERR_GRP  = 32'h0000_04FC;
  localparam logic [REG_W-1:0] STAT_IMP = 32'hFFFF_84FF;

  typedef struct packed {
    logic       en;
    logic       quiet;
    logic [1:0] width;
    logic       autoclr;
  } sctl_t;
endpackage

// File: rtl/lpc_irq_latch.sv
module lpc_irq_latch
  import lpc_irq_pkg::*;
#(
  parameter int W  = REG_W,
  parameter int NS = SIRQ_N
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NS-1:0]   sirq_lvl,
  input  logic            sirq_en,
  input  logic            auto_clr,
  input  logic [W-NS-1:0] low_evt,
  input  logic [W-1:0]    clr_ones,
  output logic [W-1:0]    stat_q
);
  localparam int LOW_N = W - NS;

  logic [NS-1:0] lvl_gated;
  logic [W-1:0]  stat_nxt;
  logic [W-1:0]  stat_r;

  assign lvl_gated = sirq_lvl & {NS{sirq_en}};

  generate
    for (genvar b = 0; b < W; b++) begin : g_bit
      if (b >= LOW_N) begin : g_sirq
        localparam int N = W - 1 - b;
        assign stat_nxt[b] = auto_clr    ? lvl_gated[N] :
                             clr_ones[b] ? 1'b0 :
                             (stat_r[b] | lvl_gated[N]);

        // R6
        auto_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
          auto_clr |=> (stat_q[b] == $past(lvl_gated[N])));

        // R5
        sirq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
          (!auto_clr && clr_ones[b]) |=> !stat_q[b]);
      end else begin : g_evt
        assign stat_nxt[b] = (stat_r[b] & ~clr_ones[b]) | low_evt[b];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_r <= '0;
    else        stat_r <= stat_nxt;
  end

  assign stat_q = stat_r;

  // R3
  evt_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (low_evt != '0) |=> ((stat_q[LOW_N-1:0] & $past(low_evt)) == $past(low_evt)));

  // R2
  sirq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sirq_en |=> ((stat_q[W-1:LOW_N] & ~$past(stat_q[W-1:LOW_N])) == '0));
endmodule

// File: rtl/lpc_irq_errcap.sv
module lpc_irq_errcap #(
  parameter int AW_E = 32,
  parameter int NE   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NE-1:0]   err_evt,
  input  logic [AW_E-1:0] err_addr,
  input  logic            grp_busy,
  output logic [AW_E-1:0] addr_q
);
  logic            cap_en;
  logic [AW_E-1:0] addr_nxt;
  logic [AW_E-1:0] addr_r;

  assign cap_en = (|err_evt) & ~grp_busy;

  always_comb begin
    addr_nxt = addr_r;
    if (cap_en) addr_nxt = err_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_r <= '0;
    else        addr_r <= addr_nxt;
  end

  assign addr_q = addr_r;

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grp_busy |=> $stable(addr_q));

  // R9
  addr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|err_evt) && !grp_busy) |=> (addr_q == $past(err_addr)));
endmodule

// File: rtl/lpc_irq_cascade.sv
module lpc_irq_cascade (
  input  logic clk,
  input  logic rst_n,
  input  logic host_irq,
  input  logic wr_stat,
  input  logic wr_mask,
  input  logic wr_pol,
  input  logic wbit,
  output logic st_q,
  output logic mk_q,
  output logic pol_q,
  output logic master_irq
);
  logic st_nxt, mk_nxt, pol_nxt;
  logic st_r, mk_r, pol_r;

  always_comb begin
    st_nxt  = (st_r & ~(wr_stat & wbit)) | host_irq;
    mk_nxt  = wr_mask ? wbit : mk_r;
    pol_nxt = wr_pol  ? wbit : pol_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_r  <= 1'b0;
      mk_r  <= 1'b0;
      pol_r <= 1'b0;
    end else begin
      st_r  <= st_nxt;
      mk_r  <= mk_nxt;
      pol_r <= pol_nxt;
    end
  end

  assign st_q       = st_r;
  assign mk_q       = mk_r;
  assign pol_q      = pol_r;
  assign master_irq = (st_r & mk_r) ^ pol_r;

  // R10
  casc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |=> st_q);

  // R10
  casc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wbit && !host_irq) |=> !st_q);
endmodule

// File: rtl/lpc_irq_hub.sv
module lpc_irq_hub
  import lpc_irq_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = REG_W,
  parameter int NS = SIRQ_N,
  parameter int NE = ERR_N
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_sel,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [NS-1:0] sirq_lvl,
  input  logic          bus_rst_evt,
  input  logic [NE-1:0] err_evt,
  input  logic [DW-1:0] err_addr,
  input  logic [BM_N-1:0] bm_req,
  output logic          host_irq,
  output logic          master_irq
);
  localparam int LOW_N = DW - NS;
  localparam logic [AW-1:0] A_SCTL  = AW'(OFS_SCTL);
  localparam logic [AW-1:0] A_MASK  = AW'(OFS_MASK);
  localparam logic [AW-1:0] A_STAT  = AW'(OFS_STAT);
  localparam logic [AW-1:0] A_EADR  = AW'(OFS_EADR);
  localparam logic [AW-1:0] A_MSTAT = AW'(OFS_MSTAT);
  localparam logic [AW-1:0] A_MMASK = AW'(OFS_MMASK);
  localparam logic [AW-1:0] A_MPOL  = AW'(OFS_MPOL);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  // write decode
  logic wr_go;
  logic wr_sctl, wr_mask, wr_stat, wr_mstat, wr_mmask, wr_mpol;

  assign wr_go    = reg_sel & reg_wr;
  assign wr_sctl  = wr_go & (reg_addr == A_SCTL);
  assign wr_mask  = wr_go & (reg_addr == A_MASK);
  assign wr_stat  = wr_go & (reg_addr == A_STAT);
  assign wr_mstat = wr_go & (reg_addr == A_MSTAT);
  assign wr_mmask = wr_go & (reg_addr == A_MMASK);
  assign wr_mpol  = wr_go & (reg_addr == A_MPOL);

  // serial control register
  sctl_t sctl_r, sctl_nxt;

  always_comb begin
    sctl_nxt = sctl_r;
    if (wr_sctl) begin
      sctl_nxt.en      = reg_wdata[SCTL_EN];
      sctl_nxt.quiet   = reg_wdata[SCTL_QUIET];
      sctl_nxt.width   = reg_wdata[SCTL_WHI:SCTL_WLO];
      sctl_nxt.autoclr = reg_wdata[SCTL_AUTO];
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) sctl_r <= '0;
    else        sctl_r <= sctl_nxt;
  end

  // enable mask register
  logic [DW-1:0] mask_r, mask_nxt;

  always_comb begin
    mask_nxt = mask_r;
    if (wr_mask) mask_nxt = reg_wdata & STAT_IMP;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) mask_r <= '0;
    else        mask_r <= mask_nxt;
  end

  // event vector for the low status bits
  logic [LOW_N-1:0] low_evt;

  always_comb begin
    low_evt                               = '0;
    low_evt[BIT_BUSRST]                   = bus_rst_evt;
    low_evt[BIT_ERR_LO+NE-1:BIT_ERR_LO]   = err_evt;
    low_evt[BIT_BM0]                      = bm_req[0];
    low_evt[BIT_BM1]                      = bm_req[1];
  end

  logic [DW-1:0] clr_ones;
  logic [DW-1:0] stat_q;

  assign clr_ones = wr_stat ? reg_wdata : '0;

  lpc_irq_latch #(.W(DW), .NS(NS)) u_latch (
    .clk      (clk),
    .rst_n    (rst_i),
    .sirq_lvl (sirq_lvl),
    .sirq_en  (sctl_r.en),
    .auto_clr (sctl_r.autoclr),
    .low_evt  (low_evt),
    .clr_ones (clr_ones),
    .stat_q   (stat_q)
  );

  logic          grp_busy;
  logic [DW-1:0] eaddr_q;

  assign grp_busy = |(stat_q & ERR_GRP);

  lpc_irq_errcap #(.AW_E(DW), .NE(NE)) u_errcap (
    .clk      (clk),
    .rst_n    (rst_i),
    .err_evt  (err_evt),
    .err_addr (err_addr),
    .grp_busy (grp_busy),
    .addr_q   (eaddr_q)
  );

  assign host_irq = |(stat_q & mask_r);

  logic mst_q, mmk_q, mpol_q;

  lpc_irq_cascade u_casc (
    .clk        (clk),
    .rst_n      (rst_i),
    .host_irq   (host_irq),
    .wr_stat    (wr_mstat),
    .wr_mask    (wr_mmask),
    .wr_pol     (wr_mpol),
    .wbit       (reg_wdata[BIT_CASC]),
    .st_q       (mst_q),
    .mk_q       (mmk_q),
    .pol_q      (mpol_q),
    .master_irq (master_irq)
  );

  // read mux
  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_SCTL: begin
        reg_rdata[SCTL_EN]           = sctl_r.en;
        reg_rdata[SCTL_QUIET]        = sctl_r.quiet;
        reg_rdata[SCTL_WHI:SCTL_WLO] = sctl_r.width;
        reg_rdata[SCTL_AUTO]         = sctl_r.autoclr;
      end
      A_MASK:  reg_rdata = mask_r;
      A_STAT:  reg_rdata = stat_q;
      A_EADR:  reg_rdata = eaddr_q;
      A_MSTAT: reg_rdata[BIT_CASC] = mst_q;
      A_MMASK: reg_rdata[BIT_CASC] = mmk_q;
      A_MPOL:  reg_rdata[BIT_CASC] = mpol_q;
      default: reg_rdata = '0;
    endcase
  end

  // R7
  mask_impl_chk: assert property (@(posedge clk) disable iff (!rst_i)
    wr_mask |=> ((mask_r & ~STAT_IMP) == '0));
endmodule

// File: tb/lpc_irq_hub_test.sv
module lpc_irq_hub_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_sel, reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [16:0] sirq_lvl;
  logic        bus_rst_evt;
  logic [5:0]  err_evt;
  logic [31:0] err_addr;
  logic [1:0]  bm_req;
  logic        host_irq, master_irq;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  lpc_irq_hub uut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sirq_lvl(sirq_lvl), .bus_rst_evt(bus_rst_evt), .err_evt(err_evt),
    .err_addr(err_addr), .bm_req(bm_req), .host_irq(host_irq),
    .master_irq(master_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic rdchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic pulse(input logic rst_e, input logic [5:0] e, input logic [1:0] bm,
                       input logic [31:0] ad);
    @(negedge clk);
    bus_rst_evt = rst_e; err_evt = e; bm_req = bm; err_addr = ad;
    @(negedge clk);
    bus_rst_evt = 1'b0; err_evt = '0; bm_req = '0;
  endtask

  task automatic t_reset();
    rdchk("R1 sctl", 8'h30, 32'h0);
    rdchk("R1 mask", 8'h34, 32'h0);
    rdchk("R1 stat", 8'h38, 32'h0);
    rdchk("R1 eadr", 8'h40, 32'h0);
    rdchk("R1 mstat", 8'h50, 32'h0);
    rdchk("R1 mmask", 8'h54, 32'h0);
    rdchk("R1 mpol", 8'h58, 32'h0);
    chk("R1 host_irq", {31'd0, host_irq}, 32'h0);
    chk("R1 master_irq", {31'd0, master_irq}, 32'h0);
  endtask

  task automatic t_sirq_gate();
    sirq_lvl = 17'h10001;
    tick(); tick();
    rdchk("R2 disabled ignored", 8'h38, 32'h0);
    wr(8'h30, 32'h8000_0000);
    tick();
    rdchk("R2 enabled latch", 8'h38, 32'h8000_8000);
  endtask

  task automatic t_rearm();
    wr(8'h38, 32'h8000_0000);
    rdchk("R5 right after clear", 8'h38, 32'h0000_8000);
    tick();
    rdchk("R5 re-armed", 8'h38, 32'h8000_8000);
    sirq_lvl = '0;
    wr(8'h38, 32'hFFFF_8000);
    tick();
    rdchk("R5 stays clear when low", 8'h38, 32'h0);
  endtask

  task automatic t_auto();
    wr(8'h30, 32'h8080_0000);
    @(negedge clk); sirq_lvl = 17'h00008;
    tick();
    rdchk("R6 auto follows high", 8'h38, 32'h1000_0000);
    sirq_lvl = '0;
    tick();
    rdchk("R6 auto falls", 8'h38, 32'h0);
    wr(8'h30, 32'h0);
  endtask

  task automatic t_events();
    pulse(1'b1, 6'b000001, 2'b01, 32'h0);
    rdchk("R3 event bits", 8'h38, 32'h0000_0406);
    pulse(1'b0, 6'b100000, 2'b10, 32'h0);
    rdchk("R3 more event bits", 8'h38, 32'h0000_0487);
    wr(8'h38, 32'h0);
    rdchk("R4 zero write no effect", 8'h38, 32'h0000_0487);
    wr(8'h38, 32'h0000_0004);
    rdchk("R4 one clears", 8'h38, 32'h0000_0483);
    wr(8'h38, 32'hFFFF_FFFF);
    rdchk("R4 clear all", 8'h38, 32'h0);
    @(negedge clk);
    err_evt = 6'b000001;
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = 8'h38; reg_wdata = 32'h4;
    @(negedge clk);
    err_evt = '0; reg_sel = 1'b0; reg_wr = 1'b0;
    rdchk("R4 set beats clear", 8'h38, 32'h0000_0004);
    wr(8'h38, 32'hFFFF_FFFF);
  endtask

  task automatic t_erraddr();
    pulse(1'b0, 6'b001000, 2'b00, 32'h0001_2345);
    rdchk("R9 first capture", 8'h40, 32'h0001_2345);
    pulse(1'b0, 6'b000010, 2'b00, 32'hDEAD_0000);
    rdchk("R9 second ignored", 8'h40, 32'h0001_2345);
    wr(8'h38, 32'h0000_04FC);
    pulse(1'b0, 6'b000000, 2'b10, 32'h0);
    rdchk("R9 request bit only", 8'h38, 32'h0000_0001);
    pulse(1'b0, 6'b100000, 2'b00, 32'hCAFE_0010);
    rdchk("R9 capture after clear", 8'h40, 32'hCAFE_0010);
    wr(8'h38, 32'hFFFF_FFFF);
    pulse(1'b1, 6'b000000, 2'b00, 32'h0);
    pulse(1'b0, 6'b000100, 2'b00, 32'h7777_7777);
    rdchk("R9 bus reset blocks", 8'h40, 32'hCAFE_0010);
    wr(8'h38, 32'hFFFF_FFFF);
  endtask

  task automatic t_ctl();
    wr(8'h30, 32'hFFFF_FFFF);
    rdchk("R8 control fields", 8'h30, 32'hC380_0000);
    wr(8'h30, 32'h0);
    rdchk("R8 control cleared", 8'h30, 32'h0);
  endtask

  task automatic t_mask_cascade();
    wr(8'h34, 32'hFFFF_FFFF);
    rdchk("R7 mask readback", 8'h34, 32'hFFFF_84FF);
    wr(8'h34, 32'h0000_0004);
    pulse(1'b1, 6'b000000, 2'b00, 32'h0);
    chk("R7 unmasked bit quiet", {31'd0, host_irq}, 32'h0);
    pulse(1'b0, 6'b000001, 2'b00, 32'h0);
    chk("R7 masked bit fires", {31'd0, host_irq}, 32'h1);
    tick();
    rdchk("R10 upstream set", 8'h50, 32'h0000_0800);
    chk("R11 mask off", {31'd0, master_irq}, 32'h0);
    wr(8'h54, 32'hFFFF_FFFF);
    rdchk("R11 mask readback", 8'h54, 32'h0000_0800);
    chk("R11 mask on", {31'd0, master_irq}, 32'h1);
    wr(8'h58, 32'hFFFF_FFFF);
    rdchk("R11 pol readback", 8'h58, 32'h0000_0800);
    chk("R11 inverted", {31'd0, master_irq}, 32'h0);
    wr(8'h58, 32'h0);
    wr(8'h50, 32'h0000_0800);
    rdchk("R10 clear loses to host", 8'h50, 32'h0000_0800);
    wr(8'h38, 32'h0000_0404);
    chk("R7 host drops", {31'd0, host_irq}, 32'h0);
    rdchk("R10 sticky", 8'h50, 32'h0000_0800);
    wr(8'h50, 32'h0000_0800);
    rdchk("R10 cleared", 8'h50, 32'h0);
    chk("R11 idle", {31'd0, master_irq}, 32'h0);
  endtask

  task automatic t_unmapped();
    wr(8'h44, 32'hFFFF_FFFF);
    rdchk("R12 unmapped read", 8'h44, 32'h0);
    rdchk("R12 low offset read", 8'h00, 32'h0);
    rdchk("R12 mask untouched", 8'h34, 32'h0000_0004);
    rdchk("R12 status untouched", 8'h38, 32'h0);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_sel = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    sirq_lvl = '0; bus_rst_evt = 1'b0; err_evt = '0; err_addr = '0; bm_req = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_sirq_gate();
    t_rearm();
    t_auto();
    t_events();
    t_erraddr();
    t_ctl();
    t_mask_cascade();
    t_unmapped();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule